// File: doc/BRIEF.md
# Serial Adder with Delayed Operand Inputs

This block adds two binary operands that arrive one bit per clock, least significant bit first. It returns their sum in the same serial form. Before the operands reach the adder, each one passes through its own shift register, four stages deep by default. Sum bit i is therefore produced four clock edges after operand bit i was applied. A single flop holds the carry from one bit position to the next.

The adding element is a full adder made of two half adders and an OR gate. The sum and carry-out pins are combinational functions of three signals: the two delayed operand bits and the registered carry. A single synchronous, active-high reset clears every flop in the block. Word boundaries are set by holding reset between words. After reset, the first bit position sees a carry-in of zero, and the carry-out pin during the last bit of a word gives that word's final carry.

Top module: `serial_adder_dly`

## Requirements
- R1: Each operand input passes through STAGES (default 4) flip-flops before the adder. The sum bit for operand bits applied before rising edge k can be read after rising edge k+3, which is the fourth edge counting the one that captured the bits.
- R2: `srst` is sampled only on the rising edge of `clk`. When it is sampled high, every delay stage and the carry flop clear to 0. Raising `srst` between edges leaves the outputs unchanged until the next rising edge.
- R3: The carry flop captures `carry_out` on each rising edge. The next bit position uses it as its carry-in, so the first bit after reset has a carry-in of 0.
- R4: `sum_ser` equals the XOR of the delayed a bit, the delayed b bit and the registered carry.
- R5: `carry_out` is 1 exactly when at least two of the three signals are 1: the delayed a bit, the delayed b bit and the registered carry.
- R6: While `srst` is held high, `sum_ser` and `carry_out` read 0 whatever `a_ser` and `b_ser` carry.
- R7: Operand bits presented while `srst` is high are discarded. If zeros follow reset release, `sum_ser` and `carry_out` stay 0 for the next four cycles.
- R8: Suppose a 4-bit word is applied LSB first, starting right after reset release. Then the four sum bits, taken in order, with `carry_out` read during the fourth sum bit as bit 4, equal the arithmetic sum a+b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| srst | input | 1 | Synchronous reset, active high |
| a_ser | input | 1 | Serial operand A, LSB first |
| b_ser | input | 1 | Serial operand B, LSB first |
| sum_ser | output | 1 | Serial sum bit, combinational from the delayed bits and carry |
| carry_out | output | 1 | Full-adder carry-out, combinational |

## Verification
The bench samples the sum at exactly the fourth edge after each operand bit. A delay line that is one stage short or long therefore shifts the reconstructed word and breaks almost every vector. Operands such as F+F and F+1 ripple a carry across all four positions. A carry flop that is missing, or that drops its value, gives the wrong upper bits and the wrong final carry. Reset is checked three ways: it must act only at a clock edge, it must hold both outputs at zero, and it must throw away ones applied while it is asserted. A reset that acts asynchronously, or one that misses some of the delay stages, would let stale ones leak into the next word.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;
  parameter int unsigned SA_STAGES = 4;

  typedef struct packed {
    logic s;
    logic c;
  } ha_out_t;
endpackage

// File: rtl/sa_delay_line.sv
module sa_delay_line #(
  parameter int unsigned STAGES = serial_add_pkg::SA_STAGES
) (
  input  logic clk,
  input  logic srst,
  input  logic din,
  output logic dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] stage_q;
  logic [LAST:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int unsigned k = 1; k < STAGES; k++) begin
      stage_d[k] = stage_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[LAST];

  // R2
  stages_cleared_chk: assert property (@(posedge clk) disable iff (srst)
    $past(srst) |-> (stage_q == '0));
endmodule

// File: rtl/sa_half_adder.sv
module sa_half_adder (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/sa_full_adder.sv
module sa_full_adder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  import serial_add_pkg::*;

  ha_out_t first;
  ha_out_t second;

  sa_half_adder u_ha_lo (.x(x),       .y(y),   .s(first.s),  .c(first.c));
  sa_half_adder u_ha_hi (.x(first.s), .y(cin), .s(second.s), .c(second.c));

  assign s    = second.s;
  assign cout = first.c | second.c;
endmodule

// File: rtl/serial_adder_dly.sv
module serial_adder_dly #(
  parameter int unsigned STAGES = serial_add_pkg::SA_STAGES
) (
  input  logic clk,
  input  logic srst,
  input  logic a_ser,
  input  logic b_ser,
  output logic sum_ser,
  output logic carry_out
);
  logic a_dly;
  logic b_dly;
  logic carry_q;
  logic carry_d;

  sa_delay_line #(.STAGES(STAGES)) u_dly_a (
    .clk(clk), .srst(srst), .din(a_ser), .dout(a_dly)
  );
  sa_delay_line #(.STAGES(STAGES)) u_dly_b (
    .clk(clk), .srst(srst), .din(b_ser), .dout(b_dly)
  );

  sa_full_adder u_fa (
    .x(a_dly), .y(b_dly), .cin(carry_q), .s(sum_ser), .cout(carry_out)
  );

  always_comb begin
    carry_d = carry_out;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      carry_q <= 1'b0;
    end else begin
      carry_q <= carry_d;
    end
  end

  // R4
  sum_parity_chk: assert property (@(posedge clk) disable iff (srst)
    sum_ser == (a_dly ^ b_dly ^ carry_q));

  // R5
  carry_majority_chk: assert property (@(posedge clk) disable iff (srst)
    carry_out == ($countones({a_dly, b_dly, carry_q}) >= 2));

  // R3
  carry_chain_chk: assert property (@(posedge clk) disable iff (srst)
    (!$past(srst) && $past(carry_out) && (a_dly || b_dly)) |-> carry_out);

  // R2
  carry_cleared_chk: assert property (@(posedge clk) disable iff (srst)
    $past(srst) |-> !carry_q);
endmodule

// File: tb/serial_adder_dly_bench.sv
module serial_adder_dly_bench;
  logic clk = 1'b0;
  logic srst = 1'b1;
  logic a_ser = 1'b0;
  logic b_ser = 1'b0;
  logic sum_ser;
  logic carry_out;
  int   vectors = 0;
  int   miss = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  serial_adder_dly u_serial_adder_dly (
    .clk(clk), .srst(srst), .a_ser(a_ser), .b_ser(b_ser),
    .sum_ser(sum_ser), .carry_out(carry_out)
  );

  localparam int NVEC = 12;
  localparam logic [12:0] VEC [NVEC] = '{
    {4'h0, 4'h0, 5'h00}, {4'hF, 4'hF, 5'h1E}, {4'hF, 4'h1, 5'h10},
    {4'h8, 4'h8, 5'h10}, {4'h5, 4'hA, 5'h0F}, {4'h7, 4'h9, 5'h10},
    {4'h3, 4'h6, 5'h09}, {4'hC, 4'h5, 5'h11}, {4'h1, 4'h1, 5'h02},
    {4'hE, 4'h3, 5'h11}, {4'h6, 4'hB, 5'h11}, {4'h9, 4'h4, 5'h0D}
  };

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    vectors++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run_word(input logic [3:0] av, input logic [3:0] bv, input logic [4:0] ex);
    logic [4:0] got;
    got = '0;
    srst = 1'b1; a_ser = 1'b0; b_ser = 1'b0;
    repeat (2) @(negedge clk);
    srst = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (c >= 4) got[c-4] = sum_ser;
      if (c == 7) got[4] = carry_out;
      if (c < 4) begin a_ser = av[c]; b_ser = bv[c]; end
      else begin a_ser = 1'b0; b_ser = 1'b0; end
      @(negedge clk);
    end
    check($sformatf("R8/R1/R3/R4/R5 %h+%h", av, bv), got, ex);
  endtask

  initial begin
    logic [3:0] ra;
    logic [3:0] rb;
    // R6 / R2: reset state with ones on the inputs
    srst = 1'b1; a_ser = 1'b1; b_ser = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 outputs held low in reset", {3'b0, sum_ser, carry_out}, 5'b0);
    // R7: ones fed during reset are discarded
    srst = 1'b0; a_ser = 1'b0; b_ser = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R7 no leak after release", {3'b0, sum_ser, carry_out}, 5'b0);
    end
    // R1: ones reach the adder after four edges, not three
    a_ser = 1'b1; b_ser = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 not yet at third edge", {4'b0, carry_out}, 5'b0);
    @(negedge clk);
    check("R1 arrived at fourth edge", {4'b0, carry_out}, 5'b1);
    // R2: reset acts only at the clock edge
    srst = 1'b1;
    #1;
    check("R2 no clear before edge", {4'b0, carry_out}, 5'b1);
    @(negedge clk);
    check("R2 cleared at edge", {3'b0, sum_ser, carry_out}, 5'b0);
    a_ser = 1'b0; b_ser = 1'b0;
    // vector table
    for (int i = 0; i < NVEC; i++) begin
      run_word(VEC[i][12:9], VEC[i][8:5], VEC[i][4:0]);
    end
    // random words against arithmetic reference
    for (int i = 0; i < 24; i++) begin
      ra = 4'($urandom);
      rb = 4'($urandom);
      run_word(ra, rb, {1'b0, ra} + {1'b0, rb});
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miss++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end
endmodule